// File: doc/BRIEF.md
# Next Program Counter Unit

This block decides where a 32-bit single-issue processor fetches next. Each cycle it receives the decoded control-transfer class of the current instruction together with the operands that class needs: a 16-bit word displacement for conditional branches, a 26-bit target field for direct jumps, a register value for register-indirect jumps, and two source operands for the equality test. It produces the next program counter combinationally and holds the program counter register itself.

Branch targets are relative to the address of the following instruction: the sign-extended displacement counts words and is added to PC+4. Direct jumps are pseudo-direct: the top four bits of PC+4 are kept and the remaining bits come from the instruction field followed by two zero bits. A jump-and-link also asks the register file to write the return address into register 31. A taken flag tells fetch logic that the sequential instruction stream is being abandoned. An enable input lets a stalled pipeline freeze the program counter.

Top module: `npc_unit`

## Requirements
- R1: After reset the program counter output equals the reset vector parameter (default 32'hBFC0_0000).
- R2: Class code 0 (sequential), and the unused codes 6 and 7, give a next PC of PC+4 with the taken flag low and no link write.
- R3: Class code 1 (branch on equal) is taken exactly when the two source operands are equal; class code 2 (branch on not equal) is taken exactly when they differ.
- R4: A taken branch gives a next PC of PC+4 plus the sign-extended 16-bit displacement shifted left by two; an untaken branch gives PC+4 with the taken flag low.
- R5: Class code 3 (jump) gives a next PC formed from bits 31:28 of PC+4, then the 26-bit field, then two zero bits.
- R6: Class code 4 (jump and link) gives the same target as R5 and raises the link write request with link address 31 and link data PC+4; no other class raises the link write request.
- R7: Class code 5 (register jump) gives a next PC equal to the register jump operand.
- R8: The taken flag is high for every jump class (3, 4, 5) and for every taken branch, and low otherwise.
- R9: On a clock edge with the enable input high the program counter takes the next PC; with enable low it keeps its value, even when the instruction transfers control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Program counter update enable (low = stall) |
| class_i | input | 3 | Control-transfer class code |
| disp_i | input | 16 | Branch displacement in words, signed |
| jfield_i | input | 26 | Pseudo-direct jump field |
| jr_src_i | input | 32 | Register operand for register jumps |
| rs_val_i | input | 32 | First compare operand |
| rt_val_i | input | 32 | Second compare operand |
| pc_o | output | 32 | Current program counter |
| npc_o | output | 32 | Next program counter |
| taken_o | output | 1 | Control transfer taken |
| link_we_o | output | 1 | Link register write request |
| link_addr_o | output | 5 | Link register index |
| link_data_o | output | 32 | Return address (PC+4) |

## Verification
The bench builds the unit with its default widths and a nonzero reset vector so that the reset value is distinguishable from zero. It sweeps all eight class codes against displacement extremes (zero, one, minus one, largest positive, most negative) and both equal and unequal operand pairs, each from several starting PCs loaded through register jumps. One starting PC sits in the last word of a 256 MB region, so PC+4 crosses into the next region and shows whether jump upper bits come from PC+4 rather than PC; stalls are interleaved with transfers to check that the register holds.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    XF_SEQ = 3'd0,
    XF_BEQ = 3'd1,
    XF_BNE = 3'd2,
    XF_JMP = 3'd3,
    XF_JAL = 3'd4,
    XF_JR  = 3'd5
  } xfer_e;
endpackage

// File: rtl/npc_cmp.sv
module npc_cmp #(
  parameter int W = 32
) (
  input  logic [2:0]   class_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         br_take_o
);
  import npc_pkg::*;
  logic eq;
  assign eq = (a_i == b_i);

  always_comb begin
    unique case (class_i)
      XF_BEQ:  br_take_o = eq;
      XF_BNE:  br_take_o = !eq;
      default: br_take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_tgt.sv
module npc_tgt #(
  parameter int W  = 32,
  parameter int DW = 16,
  parameter int JW = 26
) (
  input  logic [W-1:0]  pc_i,
  input  logic [DW-1:0] disp_i,
  input  logic [JW-1:0] jfield_i,
  output logic [W-1:0]  seq_o,
  output logic [W-1:0]  br_tgt_o,
  output logic [W-1:0]  j_tgt_o
);
  localparam int UW = W - JW - 2;   // region bits kept for pseudo-direct jumps
  localparam int XW = W - DW - 2;   // sign-extension width of the byte offset

  logic [W-1:0] offs;

  assign seq_o    = pc_i + W'(4);
  assign offs     = {{XW{disp_i[DW-1]}}, disp_i, 2'b00};
  assign br_tgt_o = seq_o + offs;
  assign j_tgt_o  = {seq_o[W-1:W-UW], jfield_i, 2'b00};
endmodule

// File: rtl/npc_sel.sv
module npc_sel #(
  parameter int W = 32
) (
  input  logic [2:0]   class_i,
  input  logic         br_take_i,
  input  logic [W-1:0] seq_i,
  input  logic [W-1:0] br_tgt_i,
  input  logic [W-1:0] j_tgt_i,
  input  logic [W-1:0] jr_src_i,
  output logic [W-1:0] npc_o,
  output logic         taken_o,
  output logic         link_we_o
);
  import npc_pkg::*;

  always_comb begin
    npc_o     = seq_i;
    taken_o   = 1'b0;
    link_we_o = 1'b0;
    unique case (class_i)
      XF_BEQ, XF_BNE: begin
        taken_o = br_take_i;
        if (br_take_i) npc_o = br_tgt_i;
      end
      XF_JMP: begin
        taken_o = 1'b1;
        npc_o   = j_tgt_i;
      end
      XF_JAL: begin
        taken_o   = 1'b1;
        link_we_o = 1'b1;
        npc_o     = j_tgt_i;
      end
      XF_JR: begin
        taken_o = 1'b1;
        npc_o   = jr_src_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int          W         = 32,
  parameter int          DW        = 16,
  parameter int          JW        = 26,
  parameter int          RW        = 5,
  parameter int          LINK_REG  = 31,
  parameter logic [31:0] RESET_VEC = 32'hBFC0_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [2:0]    class_i,
  input  logic [DW-1:0] disp_i,
  input  logic [JW-1:0] jfield_i,
  input  logic [W-1:0]  jr_src_i,
  input  logic [W-1:0]  rs_val_i,
  input  logic [W-1:0]  rt_val_i,
  output logic [W-1:0]  pc_o,
  output logic [W-1:0]  npc_o,
  output logic          taken_o,
  output logic          link_we_o,
  output logic [RW-1:0] link_addr_o,
  output logic [W-1:0]  link_data_o
);
  import npc_pkg::*;

  logic [W-1:0] pc_q, seq, br_tgt, j_tgt;
  logic         br_take;

  npc_cmp #(.W(W)) u_cmp (
    .class_i  (class_i),
    .a_i      (rs_val_i),
    .b_i      (rt_val_i),
    .br_take_o(br_take)
  );

  npc_tgt #(.W(W), .DW(DW), .JW(JW)) u_tgt (
    .pc_i    (pc_q),
    .disp_i  (disp_i),
    .jfield_i(jfield_i),
    .seq_o   (seq),
    .br_tgt_o(br_tgt),
    .j_tgt_o (j_tgt)
  );

  npc_sel #(.W(W)) u_sel (
    .class_i  (class_i),
    .br_take_i(br_take),
    .seq_i    (seq),
    .br_tgt_i (br_tgt),
    .j_tgt_i  (j_tgt),
    .jr_src_i (jr_src_i),
    .npc_o    (npc_o),
    .taken_o  (taken_o),
    .link_we_o(link_we_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_q <= W'(RESET_VEC);
    else if (en_i) pc_q <= npc_o;
  end

  assign pc_o        = pc_q;
  assign link_addr_o = RW'(LINK_REG);
  assign link_data_o = seq;

  p_seq_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && class_i == XF_SEQ) |=> (pc_o == $past(pc_o) + W'(4)));

  p_beq_eq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_i == XF_BEQ && rs_val_i == rt_val_i) |-> taken_o);

  p_bne_eq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_i == XF_BNE && rs_val_i == rt_val_i) |-> !taken_o);

  p_fallthru_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |-> (npc_o == pc_o + W'(4)));

  p_link_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (taken_o && link_data_o == pc_o + W'(4)));

  p_jr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_i == XF_JR) |-> (npc_o == jr_src_i && taken_o));

  p_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(pc_o));
endmodule

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
  localparam logic [31:0] RV = 32'hBFC0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  cls = 3'd0;
  logic [15:0] disp = '0;
  logic [25:0] jf = '0;
  logic [31:0] jr = '0, rs = '0, rt = '0;
  logic [31:0] pc, npc, ldata;
  logic        taken, lwe;
  logic [4:0]  laddr;

  int checks = 0;
  int fails = 0;
  logic [31:0] exp_pc;

  always #2 clk = ~clk;

  npc_unit #(.RESET_VEC(RV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .class_i(cls),
    .disp_i(disp), .jfield_i(jf), .jr_src_i(jr),
    .rs_val_i(rs), .rt_val_i(rt),
    .pc_o(pc), .npc_o(npc), .taken_o(taken),
    .link_we_o(lwe), .link_addr_o(laddr), .link_data_o(ldata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic [15:0] d, input logic [25:0] j,
                      input logic [31:0] r, input logic [31:0] a, input logic [31:0] b,
                      input logic e);
    logic [31:0] seq, enpc;
    logic        etk, elk;
    @(negedge clk);
    cls = c; disp = d; jf = j; jr = r; rs = a; rt = b; en = e;
    #0.5;
    seq = exp_pc + 32'd4;
    enpc = seq; etk = 1'b0; elk = 1'b0;
    case (c)
      3'd1: if (a == b) begin etk = 1'b1; enpc = seq + {{14{d[15]}}, d, 2'b00}; end
      3'd2: if (a != b) begin etk = 1'b1; enpc = seq + {{14{d[15]}}, d, 2'b00}; end
      3'd3: begin etk = 1'b1; enpc = {seq[31:28], j, 2'b00}; end
      3'd4: begin etk = 1'b1; elk = 1'b1; enpc = {seq[31:28], j, 2'b00}; end
      3'd5: begin etk = 1'b1; enpc = r; end
      default: ;
    endcase
    case (c)
      3'd1, 3'd2: chk("R3/R4 branch npc", npc, enpc);
      3'd3:       chk("R5 jump npc", npc, enpc);
      3'd4:       chk("R6 jal npc", npc, enpc);
      3'd5:       chk("R7 jr npc", npc, enpc);
      default:    chk("R2 seq npc", npc, enpc);
    endcase
    chk("R8 taken flag", {31'd0, taken}, {31'd0, etk});
    chk("R6 link write", {31'd0, lwe}, {31'd0, elk});
    if (elk) begin
      chk("R6 link addr", {27'd0, laddr}, 32'd31);
      chk("R6 link data", ldata, seq);
    end
    @(posedge clk); #1;
    if (e) exp_pc = enpc;
    chk("R9 pc update/hold", pc, exp_pc);
  endtask

  initial begin
    logic [15:0] dl [6];
    logic [31:0] bases [4];
    exp_pc = RV;
    dl[0] = 16'h0000; dl[1] = 16'h0001; dl[2] = 16'hFFFF;
    dl[3] = 16'h7FFF; dl[4] = 16'h8000; dl[5] = 16'h1234;
    bases[0] = 32'h0FFF_FFFC; bases[1] = 32'h0000_0000;
    bases[2] = 32'h7FFF_8000; bases[3] = 32'hFFFF_FFF8;
    #5;
    chk("R1 reset pc", pc, RV);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc after release", pc, RV);
    step(3'd0, 16'h0, 26'h0, 32'h0, 32'h1, 32'h1, 1'b1);
    step(3'd3, 16'h0, 26'h3FF_FFFF, 32'h0, 32'h0, 32'h0, 1'b0);
    for (int bi = 0; bi < 4; bi++)
      for (int c = 0; c < 8; c++)
        for (int di = 0; di < 6; di++)
          for (int eq = 0; eq < 2; eq++) begin
            logic [31:0] a, b;
            a = 32'hA5A5_0000 ^ (32'(c) << 8) ^ 32'(di);
            b = eq ? a : (a ^ (32'h1 << (di * 5)));
            step(3'd5, 16'h0, 26'h0, bases[bi], 32'h0, 32'h0, 1'b1);
            step(3'(c), dl[di], 26'h155_5555 ^ 26'(di << 20), 32'h1357_9BDF ^ 32'(c),
                 a, b, 1'b1);
            step(3'(c), dl[di], 26'h2AA_AAAA, 32'h0246_8ACE, a, a ^ 32'(eq), 1'b0);
          end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule